// File: doc/BRIEF.md
# Calibrated Real-Time Clock Prescaler

This block turns a nominal 32.768 kHz oscillator clock into a one-second timekeeping strobe. A binary prescaler counts input cycles. A signed digital trim speeds it up or slows it down by a small programmed amount to cancel the crystal's frequency error. The trim works on a fixed window of input cycles. Within each window the prescaler is given a set number of extra counts (for a slow crystal) or loses a set number of counts (for a fast crystal). These events are spread evenly across the window rather than grouped together.

Software programs the block through two small registers. One holds a calibration-mode flag. The other holds a 5-bit trim magnitude and a direction bit, and it accepts writes only while calibration mode is on. A single shared output pin carries a roughly 512 Hz square wave while calibration mode is on, so the raw crystal error can be measured. At all other times the pin passes the power-fail indication through.

The measurement tone comes from a free-running divider that the trim never touches, so it always shows the uncorrected oscillator. A new trim value takes effect only at the start of the next correction window.

Top module: `rtc_cal_divider`

## Requirements
- R1: With a trim magnitude of 0, `tick` goes high for exactly one cycle every 2^P_W input cycles.
- R2: While `rst` is high at a clock edge, the prescaler, the window counter, the accumulator, the trim registers and the mode flag are cleared. After reset, `tick` is 0 and both registers read back as 0.
- R3: A write to address 0 loads the calibration-mode flag from data bit 0. A read of address 0 returns that flag in bit 0 and zeros elsewhere.
- R4: While the mode flag is 0, `pin_out` equals `pwr_fail` in the same cycle.
- R5: While the mode flag is 1, `pin_out` shows a square wave with a period of 2^SQ_W input cycles. The wave is high for the second half of each period and is counted from reset. The trim never changes it.
- R6: A write to address 1 is ignored unless the mode flag was already 1 before that clock edge. An ignored write leaves the address 1 readback unchanged.
- R7: With the direction bit at 1, each window holds magnitude×PPL cycles in which the prescaler advances by 2 instead of 1. This shortens the tick interval.
- R8: With the direction bit at 0, each window holds magnitude×PPL cycles in which the prescaler does not advance. This lengthens the tick interval.
- R9: The trim value is captured from the register in the first cycle of each 2^WIN_W-cycle window, and the accumulator restarts from 0 in that cycle. In every cycle the accumulator adds magnitude×PPL. A correction happens in a cycle where the sum reaches 2^WIN_W, and the accumulator then keeps the remainder.
- R10: A read of address 1 returns the magnitude in bits 4:0 and the direction bit in bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, nominally 32.768 kHz |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 mode flag, 1 trim |
| wr_data | input | MAG_W+1 | Write data |
| rd_addr | input | 1 | Read address |
| rd_data | output | MAG_W+1 | Combinational read data |
| pwr_fail | input | 1 | Power-fail indication routed to the shared pin |
| tick | output | 1 | One-cycle seconds strobe |
| pin_out | output | 1 | Shared pin: measurement tone or power-fail |

## Verification
The properties assume a synchronous write interface: `wr_en`, `wr_addr` and `wr_data` settle before each rising edge, and the trim magnitude times PPL stays below the window length. The properties also assume that PPL and the window are sized so that the prescaler never wraps twice in one window position. The stimulus changes inputs only just after a rising edge. It uses a reduced prescaler and window through parameters, and keeps every programmed trim within the 5-bit field, so these assumptions always hold.

// File: rtl/rtc_cal_divider.sv
module rtc_cal_divider #(
  parameter int P_W   = 15,
  parameter int WIN_W = 20,
  parameter int SQ_W  = 6,
  parameter int MAG_W = 5,
  parameter int PPL   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [MAG_W:0]   wr_data,
  input  logic             rd_addr,
  output logic [MAG_W:0]   rd_data,
  input  logic             pwr_fail,
  output logic             tick,
  output logic             pin_out
);
  localparam logic [WIN_W:0] PPL_V = (WIN_W+1)'(PPL);

  logic [P_W-1:0]   pre;
  logic [WIN_W-1:0] win_cnt;
  logic [WIN_W-1:0] acc;
  logic [SQ_W-1:0]  raw;
  logic             cal_mode;
  logic [MAG_W:0]   cal_reg;
  logic [MAG_W:0]   act_reg;

  logic             win_start;
  logic [MAG_W:0]   use_cal;
  logic [WIN_W:0]   mag_ext;
  logic [WIN_W:0]   sum;
  logic             evt;
  logic [1:0]       step;
  logic [P_W:0]     nxt;

  assign win_start = (win_cnt == '0);
  assign use_cal   = win_start ? cal_reg : act_reg;

  always_comb begin
    mag_ext = '0;
    mag_ext[MAG_W-1:0] = use_cal[MAG_W-1:0];
  end

  assign sum = (win_start ? '0 : {1'b0, acc}) + mag_ext * PPL_V;
  assign evt = sum[WIN_W];

  always_comb begin
    step = 2'd1;
    if (evt) step = use_cal[MAG_W] ? 2'd2 : 2'd0;
  end

  assign nxt = {1'b0, pre} + {{(P_W-1){1'b0}}, step};

  always_ff @(posedge clk) begin
    if (rst) begin
      pre      <= '0;
      win_cnt  <= '0;
      acc      <= '0;
      raw      <= '0;
      cal_mode <= 1'b0;
      cal_reg  <= '0;
      act_reg  <= '0;
      tick     <= 1'b0;
    end else begin
      pre     <= nxt[P_W-1:0];
      tick    <= nxt[P_W];
      win_cnt <= win_cnt + 1'b1;
      acc     <= sum[WIN_W-1:0];
      raw     <= raw + 1'b1;
      if (win_start) act_reg <= cal_reg;
      if (wr_en && !wr_addr) cal_mode <= wr_data[0];
      if (wr_en && wr_addr && cal_mode) cal_reg <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr) rd_data = cal_reg;
    else         rd_data[0] = cal_mode;
  end

  assign pin_out = cal_mode ? raw[SQ_W-1] : pwr_fail;
endmodule

// File: rtl/rtc_cal_divider_chk.sv
module rtc_cal_divider_chk #(
  parameter int WIN_W = 20,
  parameter int MAG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             wr_addr,
  input logic [MAG_W:0]   wr_data,
  input logic             tick,
  input logic             cal_mode,
  input logic [MAG_W:0]   cal_reg,
  input logic [MAG_W:0]   act_reg,
  input logic [WIN_W-1:0] win_cnt
);
  a_r1_tick_strobe: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  a_r3_mode_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr) |=> (cal_mode == $past(wr_data[0])));

  a_r6_locked_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr && !cal_mode) |=> $stable(cal_reg));

  a_r9_hold_active: assert property (@(posedge clk) disable iff (rst)
    (win_cnt != '0) |=> $stable(act_reg));

  a_r2_reset_clear: assert property (@(posedge clk)
    (rst && !$isunknown(rst)) |=> (!tick && !cal_mode && cal_reg == '0));
endmodule

bind rtc_cal_divider rtc_cal_divider_chk #(.WIN_W(WIN_W), .MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .tick(tick), .cal_mode(cal_mode), .cal_reg(cal_reg), .act_reg(act_reg),
  .win_cnt(win_cnt)
);

// File: tb/test_rtc_cal_divider.sv
module test_rtc_cal_divider;
  localparam int P_W = 6, WIN_W = 10, SQ_W = 6, MAG_W = 5, PPL = 4;
  localparam int PMOD = 1 << P_W, WMOD = 1 << WIN_W, SMOD = 1 << SQ_W;

  logic clk = 0, rst = 1, wr_en = 0, wr_addr = 0, rd_addr = 0, pwr_fail = 0;
  logic [MAG_W:0] wr_data = '0, rd_data;
  logic tick, pin_out;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // behavioural model state
  int m_ph = 0, m_wc = 0, m_acc = 0, m_raw = 0, m_mode = 0, m_cal = 0, m_act = 0, m_tick = 0;

  rtc_cal_divider #(.P_W(P_W), .WIN_W(WIN_W), .SQ_W(SQ_W), .MAG_W(MAG_W), .PPL(PPL)) i_rtc_cal_divider (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwr_fail(pwr_fail), .tick(tick), .pin_out(pin_out));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    int ws, use_cal, a, step, n_mode, n_cal;
    cyc++;
    if (rst) begin
      m_ph = 0; m_wc = 0; m_acc = 0; m_raw = 0; m_mode = 0; m_cal = 0; m_act = 0; m_tick = 0;
    end else begin
      ws = (m_wc == 0);
      use_cal = ws ? m_cal : m_act;
      if (ws) m_act = m_cal;
      a = (ws ? 0 : m_acc) + (use_cal % 32) * PPL;
      step = 1;
      if (a >= WMOD) begin
        a -= WMOD;
        step = (use_cal >= 32) ? 2 : 0;
      end
      m_acc = a;
      m_ph += step;
      m_tick = (m_ph >= PMOD);
      if (m_tick) m_ph -= PMOD;
      m_wc = (m_wc + 1) % WMOD;
      m_raw = (m_raw + 1) % SMOD;
      n_mode = m_mode; n_cal = m_cal;
      if (wr_en && !wr_addr) n_mode = wr_data[0];
      if (wr_en && wr_addr && m_mode) n_cal = wr_data;
      m_mode = n_mode; m_cal = n_cal;
    end
  end

  // per-cycle comparison against the model (R1, R4, R5, R7, R8, R9)
  always @(negedge clk) begin
    int exp_pin, exp_rd;
    if (!rst && !done) begin
      chk(tick == m_tick, "R9 tick vs model", tick, m_tick);
      exp_pin = m_mode ? (m_raw >= SMOD/2) : pwr_fail;
      chk(pin_out == exp_pin, m_mode ? "R5 tone" : "R4 power-fail pass", pin_out, exp_pin);
      exp_rd = rd_addr ? m_cal : m_mode;
      chk(rd_data == exp_rd, rd_addr ? "R10 readback" : "R3 readback", rd_data, exp_rd);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input bit addr, input int data);
    @(posedge clk); #1;
    wr_en = 1; wr_addr = addr; wr_data = data[MAG_W:0];
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic count_ticks(input int n, output int t);
    t = 0;
    repeat (n) begin
      @(negedge clk);
      if (tick) t++;
    end
    #1;
  endtask

  initial begin
    int t, last, gap;
    wait_cyc(4);
    rst = 0;
    @(negedge clk);
    chk(tick == 0, "R2 tick after reset", tick, 0);
    rd_addr = 0; #0.5;
    chk(rd_data == 0, "R2 mode after reset", rd_data, 0);
    rd_addr = 1; #0.5;
    chk(rd_data == 0, "R2 trim after reset", rd_data, 0);

    // R1: nominal interval with zero trim
    last = -1;
    repeat (5 * PMOD) begin
      @(negedge clk);
      if (tick) begin
        if (last >= 0) begin
          gap = cyc - last;
          chk(gap == PMOD, "R1 nominal interval", gap, PMOD);
        end
        last = cyc;
      end
    end

    // R4: power-fail follows
    pwr_fail = 1; @(negedge clk);
    chk(pin_out == 1, "R4 pin high", pin_out, 1);
    pwr_fail = 0; @(negedge clk);
    chk(pin_out == 0, "R4 pin low", pin_out, 0);

    // R6: locked write ignored
    wr(1, 6'h25);
    rd_addr = 1; @(negedge clk);
    chk(rd_data == 0, "R6 locked write ignored", rd_data, 0);

    // R3: mode on
    wr(0, 1);
    rd_addr = 0; @(negedge clk);
    chk(rd_data == 1, "R3 mode set", rd_data, 1);
    pwr_fail = 1;
    wait_cyc(3 * SMOD);

    // R10: trim readback, positive max
    wr(1, 6'h3F);
    rd_addr = 1; @(negedge clk);
    chk(rd_data == 6'h3F, "R10 trim readback", rd_data, 63);
    wait_cyc(2 * SMOD);
    wr(0, 0);
    pwr_fail = 0;

    // R7: positive trim, 4 windows advance 4096+496 counts
    wait_cyc(WMOD);
    count_ticks(4 * WMOD, t);
    chk(t >= 71 && t <= 72, "R7 insert tick count", t, 72);

    // R8: negative trim mag 31
    wr(0, 1);
    wr(1, 6'h1F);
    wr(0, 0);
    wait_cyc(WMOD);
    count_ticks(4 * WMOD, t);
    chk(t >= 56 && t <= 57, "R8 delete tick count", t, 56);

    // R9: mid-window trim change, moderate values
    wr(0, 1);
    wait_cyc(WMOD / 3);
    wr(1, 6'h27);
    wait_cyc(2 * WMOD + 100);
    wr(1, 6'h0B);
    wait_cyc(2 * WMOD);

    // R2: reset again mid-run
    @(posedge clk); #1; rst = 1;
    wait_cyc(2); rst = 0;
    @(negedge clk);
    rd_addr = 0; #0.5;
    chk(rd_data == 0, "R2 mode cleared", rd_data, 0);
    wait_cyc(3 * PMOD);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_cyc(150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule